// File: doc/BRIEF.md
# Parameterized Muller join gate library

This block is a state-holding join for asynchronous handshake control, modelled on a clock so that simulation is deterministic. Its output goes high once its inputs agree on 1 and goes low once they agree on 0. While they disagree, the output keeps its last value. A parameter picks one of three behaviours:

- **Symmetric:** every input takes part in both the rising and the falling decision.
- **Set-only:** marked inputs are needed to raise the output but are not consulted when lowering it.
- **Clear-only:** marked inputs are needed to lower the output but are not consulted when raising it.

Wide joins are built as a tree of small leaf gates. Each leaf takes at most three external signals plus its own fed-back output, which is four inputs in total, so one leaf fits one four-input cell. In the clocked model every leaf is a register, so the join answers after a fixed number of cycles equal to its tree depth.

Each input of a join acknowledges one producer. The join output becomes the combined request or acknowledge for the next stage of a four-phase protocol.

Top module: `cjoin`

## Requirements
- R1: Symmetric join: once every input has been 1 for L consecutive cycles, the output is 1.
- R2: Symmetric join: once every input has been 0 for L consecutive cycles, the output is 0.
- R3: Symmetric join: within one handshake phase (inputs only rising toward all ones, or only falling toward all zeros), any partial pattern leaves the output at its previous value.
- R4: Set-only variant (`KIND` = 1): the output rises only when every input is 1, marked inputs included. Marked inputs at 1 with an unmarked input at 0 do not raise it.
- R5: Set-only variant: the output falls once every unmarked input is 0, whatever the marked inputs hold. Marked inputs falling alone do not lower it.
- R6: Clear-only variant (`KIND` = 2): the output rises once every unmarked input is 1, whatever the marked inputs hold. Marked inputs rising alone do not raise it.
- R7: Clear-only variant: the output falls only when every input is 0, marked inputs included.
- R8: Bit i of `MARK_MASK` marks input i. The mask has no effect when `KIND` = 0 (symmetric). Bit 0 of the mask is always disregarded, so input 0 always takes part in both decisions.
- R9: Every leaf joins at most three inputs besides its own feedback, and each tree level adds one register. With no marked inputs, the latency L is the number of levels, where each level divides the width by three, rounding up: 2 for 8 inputs, 4 for 32 inputs. With marked inputs, L is the deeper of the two subtree depths plus one.
- R10: While `rst_n` is low, every stored element is cleared at once and the output is 0.
- R11: With one input and no marked inputs there is no storage. The output equals the input in the same cycle, reset included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| in_vec | input | N | Inputs to be joined |
| join_out | output | 1 | Joined output |

## Verification
The hardest case is a partial pattern that agrees inside one leaf but not across the tree. A join that let one leaf's agreement leak to the root would raise the output before the last input arrived. The rising and falling sweeps in scrambled order catch this, because the bench expects the output to hold until the final input.

For the asymmetric variants the bench applies exactly the patterns in which the marked inputs disagree with the unmarked ones. A variant that consulted marked inputs on the wrong transition would lower or raise the output there. One configuration marks bit 0, so that a design honouring that bit would clear its output where the expected output stays high.

Latency is checked cycle by cycle on the 8-wide and 32-wide trees, so a missing or extra register level shows up as an early or late edge. A mid-cycle reset must clear the output before the next edge.

// File: rtl/cjoin_pkg.sv
package cjoin_pkg;

  // Variant of the whole join, selected by the KIND parameter.
  typedef enum logic [1:0] {
    CJ_STD = 2'd0,
    CJ_POS = 2'd1,
    CJ_NEG = 2'd2
  } cj_kind_e;

  // Behaviour of a single leaf cell.
  typedef enum logic [2:0] {
    LF_C    = 3'd0,
    LF_CPOS = 3'd1,
    LF_CNEG = 3'd2,
    LF_AND  = 3'd3,
    LF_OR   = 3'd4
  } leaf_op_e;

  localparam int LEAF_FANIN = 3;
  localparam int MAX_INPUTS = 32;

  // Number of register levels in a tree of three-input leaves over n inputs.
  function automatic int tree_levels(input int n);
    int w;
    int l;
    w = n;
    l = 0;
    for (int i = 0; i < MAX_INPUTS; i++) begin
      if (w > 1) begin
        w = (w + LEAF_FANIN - 1) / LEAF_FANIN;
        l = l + 1;
      end
    end
    return l;
  endfunction

  // Width of the signal vector entering level lvl of a tree over n inputs.
  function automatic int level_width(input int n, input int lvl);
    int w;
    w = n;
    for (int i = 0; i < MAX_INPUTS; i++) begin
      if (i < lvl) w = (w + LEAF_FANIN - 1) / LEAF_FANIN;
    end
    return w;
  endfunction

  // Count of marked inputs; bit 0 never counts.
  function automatic int count_marked(input int n, input logic [31:0] mask);
    int c;
    c = 0;
    for (int i = 1; i < MAX_INPUTS; i++) begin
      if (i < n && mask[i]) c = c + 1;
    end
    return c;
  endfunction

  // Position of the k-th input whose marked state equals want.
  function automatic int marked_index(input int n, input logic [31:0] mask,
                                      input int k, input logic want);
    int c;
    int r;
    logic m;
    c = 0;
    r = 0;
    for (int i = 0; i < MAX_INPUTS; i++) begin
      m = (i != 0) && mask[i];
      if (i < n && m == want) begin
        if (c == k) r = i;
        c = c + 1;
      end
    end
    return r;
  endfunction

  // Cycles from a settled input pattern to the settled output.
  function automatic int join_latency(input int n, input cj_kind_e kind,
                                      input logic [31:0] mask);
    int nm;
    int lu;
    int lm;
    nm = (kind == CJ_STD) ? 0 : count_marked(n, mask);
    if (nm == 0) return tree_levels(n);
    lu = tree_levels(n - nm);
    lm = tree_levels(nm);
    return ((lu > lm) ? lu : lm) + 1;
  endfunction

  // Next state of one leaf: used marks live inputs, asym marks inputs
  // that are left out of the transition the variant exempts them from.
  function automatic logic leaf_next(input leaf_op_e op, input logic [2:0] a,
                                     input logic [2:0] used, input logic [2:0] asym,
                                     input logic q);
    logic all1;
    logic all0;
    logic sym1;
    logic sym0;
    logic set_c;
    logic clr_c;
    all1 = &(a | ~used);
    all0 = ~|(a & used);
    sym1 = &(a | ~used | asym);
    sym0 = ~|(a & used & ~asym);
    set_c = all1;
    clr_c = all0;
    case (op)
      LF_CPOS: clr_c = sym0;
      LF_CNEG: set_c = sym1;
      default: ;
    endcase
    if (op == LF_AND) return all1;
    if (op == LF_OR) return ~all0;
    if (set_c) return 1'b1;
    if (clr_c) return 1'b0;
    return q;
  endfunction

endpackage

// File: rtl/cjoin_leaf.sv
module cjoin_leaf
  import cjoin_pkg::*;
#(
  parameter int W = 3,
  parameter leaf_op_e OP = LF_C,
  parameter logic [2:0] ASYM = 3'b000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic         q
);

  localparam logic [2:0] USED = 3'((1 << W) - 1);

  logic [2:0] a_pad;
  logic       q_nx;

  always_comb begin
    a_pad = '0;
    a_pad[W-1:0] = a;
  end

  always_comb begin
    q_nx = leaf_next(OP, a_pad, USED, ASYM, q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end

endmodule

// File: rtl/cjoin_tree.sv
module cjoin_tree
  import cjoin_pkg::*;
#(
  parameter int N = 8,
  parameter leaf_op_e OP = LF_C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  output logic         y
);

  localparam int LEVELS = tree_levels(N);

  generate
    if (LEVELS == 0) begin : g_wire
      assign y = a[0];
    end else begin : g_tree
      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int WI = level_width(N, l);
        localparam int WO = level_width(N, l + 1);
        logic [WI-1:0] din;
        logic [WO-1:0] dout;
        if (l == 0) begin : g_first
          assign din = a;
        end else begin : g_next
          assign din = g_lvl[l-1].dout;
        end
        for (genvar j = 0; j < WO; j++) begin : g_leaf
          localparam int LO  = LEAF_FANIN * j;
          localparam int CNT = (WI - LO < LEAF_FANIN) ? (WI - LO) : LEAF_FANIN;
          cjoin_leaf #(
            .W   (CNT),
            .OP  (OP),
            .ASYM(3'b000)
          ) u_leaf (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (din[LO+CNT-1:LO]),
            .q    (dout[j])
          );
        end
      end
      assign y = g_lvl[LEVELS-1].dout[0];
    end
  endgenerate

endmodule

// File: rtl/cjoin.sv
module cjoin
  import cjoin_pkg::*;
#(
  parameter int N = 8,
  parameter cj_kind_e KIND = CJ_STD,
  parameter logic [N-1:0] MARK_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_vec,
  output logic         join_out
);

  localparam logic [31:0] MASK_EFF =
    (KIND == CJ_STD) ? 32'd0 : (32'(MARK_MASK) & ~32'd1);
  localparam int NM = count_marked(N, MASK_EFF);
  localparam int NU = N - NM;

  generate
    if (NM == 0) begin : g_sym
      cjoin_tree #(
        .N (N),
        .OP(LF_C)
      ) u_all (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (in_vec),
        .y    (join_out)
      );
    end else begin : g_asym
      localparam leaf_op_e MOP  = (KIND == CJ_POS) ? LF_AND : LF_OR;
      localparam leaf_op_e ROP  = (KIND == CJ_POS) ? LF_CPOS : LF_CNEG;
      logic [NU-1:0] unm;
      logic [NM-1:0] mrk;
      logic          unm_y;
      logic          mrk_y;

      for (genvar k = 0; k < NU; k++) begin : g_unm
        localparam int IDX = marked_index(N, MASK_EFF, k, 1'b0);
        assign unm[k] = in_vec[IDX];
      end
      for (genvar k = 0; k < NM; k++) begin : g_mrk
        localparam int IDX = marked_index(N, MASK_EFF, k, 1'b1);
        assign mrk[k] = in_vec[IDX];
      end

      cjoin_tree #(
        .N (NU),
        .OP(LF_C)
      ) u_unm (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (unm),
        .y    (unm_y)
      );

      cjoin_tree #(
        .N (NM),
        .OP(MOP)
      ) u_mrk (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (mrk),
        .y    (mrk_y)
      );

      // Bit 1 of the root carries the marked group.
      cjoin_leaf #(
        .W   (2),
        .OP  (ROP),
        .ASYM(3'b010)
      ) u_root (
        .clk  (clk),
        .rst_n(rst_n),
        .a    ({mrk_y, unm_y}),
        .q    (join_out)
      );
    end
  endgenerate

endmodule

// File: rtl/cjoin_chk.sv
module cjoin_chk
  import cjoin_pkg::*;
#(
  parameter int N = 8,
  parameter cj_kind_e KIND = CJ_STD,
  parameter logic [N-1:0] MARK_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] in_vec,
  input logic         join_out
);

  localparam logic [31:0] MK32 =
    (KIND == CJ_STD) ? 32'd0 : (32'(MARK_MASK) & ~32'd1);
  localparam logic [N-1:0] MK = MK32[N-1:0];
  localparam int LAT = join_latency(N, KIND, MK32);
  localparam logic [3:0] LAT4 = 4'(LAT);

  logic       hi_now;
  logic       lo_now;
  logic [3:0] hi_run;
  logic [3:0] lo_run;

  always_comb begin
    hi_now = (KIND == CJ_NEG) ? &(in_vec | MK) : &in_vec;
    lo_now = (KIND == CJ_POS) ? ~|(in_vec & ~MK) : ~|in_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= hi_now ? ((hi_run == 4'hF) ? hi_run : hi_run + 4'd1) : 4'd0;
      lo_run <= lo_now ? ((lo_run == 4'hF) ? lo_run : lo_run + 4'd1) : 4'd0;
    end
  end

  generate
    if (LAT > 0) begin : g_stateful
      // R1 (set condition of R4 and R6 in the asymmetric variants)
      settle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run >= LAT4) |-> join_out);

      // R2 (clear condition of R5 and R7 in the asymmetric variants)
      settle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_run >= LAT4) |-> !join_out);

      // R10
      always @(posedge clk) begin
        if (!rst_n) begin
          reset_clear_chk: assert (join_out == 1'b0);
        end
      end
    end else begin : g_wire
      // R11
      always @(posedge clk) begin
        passthru_chk: assert (join_out == in_vec[0]);
      end
    end
  endgenerate

endmodule

bind cjoin cjoin_chk #(
  .N        (N),
  .KIND     (KIND),
  .MARK_MASK(MARK_MASK)
) u_cjoin_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vec  (in_vec),
  .join_out(join_out)
);

// File: tb/cjoin_tb_top.sv
module cjoin_tb_top;
  import cjoin_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [7:0]  v8;
  logic [31:0] v32;
  logic [4:0]  vp;
  logic [4:0]  vn;
  logic [2:0]  vb;
  logic        v1;
  logic        o8;
  logic        o32;
  logic        op;
  logic        on;
  logic        ob;
  logic        o1;

  int checks;
  int fails;

  // Table entries: {expected output, input vector} for the 8-input join.
  localparam logic [8:0] TBL [0:14] = '{
    9'h000, 9'h001, 9'h00F, 9'h07F, 9'h1FF,
    9'h1FE, 9'h130, 9'h000, 9'h080, 9'h0A5,
    9'h1FF, 9'h000, 9'h1FF, 9'h101, 9'h000
  };

  cjoin #(.N(8), .KIND(CJ_STD), .MARK_MASK(8'hF0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vec(v8), .join_out(o8));
  cjoin #(.N(32), .KIND(CJ_STD), .MARK_MASK(32'h0)) dut_wide_i (
    .clk(clk), .rst_n(rst_n), .in_vec(v32), .join_out(o32));
  cjoin #(.N(5), .KIND(CJ_POS), .MARK_MASK(5'b10110)) dut_pos_i (
    .clk(clk), .rst_n(rst_n), .in_vec(vp), .join_out(op));
  cjoin #(.N(5), .KIND(CJ_NEG), .MARK_MASK(5'b10110)) dut_neg_i (
    .clk(clk), .rst_n(rst_n), .in_vec(vn), .join_out(on));
  cjoin #(.N(3), .KIND(CJ_POS), .MARK_MASK(3'b011)) dut_b0_i (
    .clk(clk), .rst_n(rst_n), .in_vec(vb), .join_out(ob));
  cjoin #(.N(1), .KIND(CJ_STD), .MARK_MASK(1'b0)) dut_one_i (
    .clk(clk), .rst_n(rst_n), .in_vec(v1), .join_out(o1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b1;
    v8 = '0; v32 = '0; vp = '0; vn = '0; vb = '0; v1 = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    // R10: every stored join reads 0 in reset
    check("R10 reset 8-wide", o8, 1'b0);
    check("R10 reset 32-wide", o32, 1'b0);
    check("R10 reset set-only", op, 1'b0);
    check("R10 reset clear-only", on, 1'b0);
    check("R10 reset bit0", ob, 1'b0);
    v1 = 1'b1;
    #1 check("R11 single input follows during reset", o1, 1'b1);
    hold(3);
    rst_n = 1'b1;
    hold(2);

    // R1 R2 R3 R8: table walk, each pattern held past the latency
    for (int i = 0; i < 15; i++) begin
      v8 = TBL[i][7:0];
      hold(4);
      check("R1 R2 R3 R8 table", o8, TBL[i][8]);
    end

    // R3: rise one input at a time in scrambled order, then fall
    v8 = '0;
    hold(4);
    for (int i = 0; i < 8; i++) begin
      v8[(i * 3) % 8] = 1'b1;
      hold(4);
      check("R3 rising sweep", o8, (i == 7));
    end
    for (int i = 0; i < 8; i++) begin
      v8[(i * 5) % 8] = 1'b0;
      hold(4);
      check("R3 falling sweep", o8, (i != 7));
    end

    // R9: exact latency of the 8-input tree (two levels)
    v8 = 8'hFF;
    @(posedge clk); #1 check("R9 8-wide one edge", o8, 1'b0);
    @(posedge clk); #1 check("R9 8-wide two edges", o8, 1'b1);
    @(negedge clk);
    v8 = 8'h00;
    hold(4);

    // R3 R9: 32-input tree, one straggler, then latency of four levels
    v32 = 32'hFFFF_FFFE;
    hold(8);
    check("R3 32-wide straggler", o32, 1'b0);
    v32 = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 check("R9 32-wide three edges", o32, 1'b0);
    @(posedge clk); #1 check("R9 32-wide four edges", o32, 1'b1);
    @(negedge clk);
    v32 = 32'h0;
    repeat (3) @(posedge clk);
    #1 check("R2 R9 32-wide fall three edges", o32, 1'b1);
    @(posedge clk); #1 check("R2 R9 32-wide fall four edges", o32, 1'b0);
    @(negedge clk);

    // R4 R5: set-only variant, inputs 1, 2 and 4 marked
    vp = 5'h16; hold(4); check("R4 marked alone do not set", op, 1'b0);
    vp = 5'h00; hold(4);
    vp = 5'h09; hold(4); check("R4 unmarked alone do not set", op, 1'b0);
    vp = 5'h1F; hold(4); check("R4 all high sets", op, 1'b1);
    vp = 5'h09; hold(4); check("R5 marked falling do not clear", op, 1'b1);
    vp = 5'h16; hold(4); check("R5 unmarked low clears", op, 1'b0);

    // R6 R7: clear-only variant, same marking
    vn = 5'h16; hold(4); check("R6 marked alone do not set", on, 1'b0);
    vn = 5'h09; hold(4); check("R6 unmarked high sets", on, 1'b1);
    vn = 5'h1F; hold(4); check("R6 stays set", on, 1'b1);
    vn = 5'h16; hold(4); check("R7 marked high holds", on, 1'b1);
    vn = 5'h00; hold(4); check("R7 all low clears", on, 1'b0);

    // R8: mask bit 0 disregarded, input 0 keeps the output up
    vb = 3'b111; hold(4); check("R8 bit0 config sets", ob, 1'b1);
    vb = 3'b011; hold(4); check("R8 input 0 still symmetric", ob, 1'b1);
    vb = 3'b000; hold(4); check("R8 bit0 config clears", ob, 1'b0);

    // R11: single input follows combinationally
    v1 = 1'b0; #1 check("R11 single input low", o1, 1'b0);
    @(negedge clk);
    v1 = 1'b1; #1 check("R11 single input high", o1, 1'b1);

    // R10: reset in mid-cycle clears at once, join rebuilds afterwards
    @(negedge clk);
    v8 = 8'hFF;
    hold(4);
    check("R1 set before reset", o8, 1'b1);
    #2 rst_n = 1'b0;
    #1 check("R10 mid-cycle reset", o8, 1'b0);
    hold(2);
    rst_n = 1'b1;
    hold(4);
    check("R1 after reset release", o8, 1'b1);

    finish_run();
  end

endmodule